// File: doc/BRIEF.md
# Serial Flash Abort Command Decoder

This block sits on the slave side of a serial flash controller model and watches the chip-select, serial clock and serial data-in lines of a mode-0 SPI link. It collects the incoming bits into bytes, most significant bit first, and looks for a two-byte abort command. The first byte is an opcode and the second a confirmation byte. When the command is complete and legal, the block tells the program/erase engine to stop. It also clears the write-enable latch and the two suspend flags in the status byte.

The command acts only when chip select goes high. It needs the abort-enable bit of the status byte to be set. It does not need a prior write-enable. It is rejected if chip select rises part way through a byte. Bytes that arrive after the confirmation byte are ignored. The three pins pass through two-flop synchronisers into the system clock domain, and every output is registered in that domain.

The status byte enters on `stat_in` and leaves on `stat_out` one clock later. The only change is the clearing of three bits when an abort fires. Status bit positions: bit 1 is the write-enable latch, bit 2 is program-suspend, bit 3 is erase-suspend and bit 4 is abort-enable. The other bits carry protection and lock settings and always pass through unchanged.

Top module: `flash_abort_decoder`

## Requirements
- R1: While `cs_n_in` is low, the block shifts in one bit on each rising edge of the synchronised `sck_in`, most significant bit first. Whenever chip select is high, the bit and byte state is cleared, so no part of the command carries from one frame into the next.
- R2: A frame whose first byte is 0xF0 and whose second byte is 0xD0 makes `abort_pulse` high for exactly one clock cycle. The pulse rises at the second clock edge after the edge that first samples `cs_n_in` high.
- R3: When `stat_in` bit 4 (abort-enable) is 0 as chip select rises, a complete and correct command produces no pulse, and `stat_out` is unchanged.
- R4: The command fires whatever the value of `stat_in` bit 1 (write-enable latch), including when it is 0.
- R5: If chip select rises after a number of clocked bits that is not a multiple of eight, no abort occurs. This includes a confirmation byte that was only partly sent.
- R6: A first byte other than 0xF0, or a second byte other than 0xD0, blocks the abort for that frame. Whole bytes sent after a correct confirmation byte do not block it.
- R7: In the clock cycle where `abort_pulse` is high, `stat_out` bits 1, 2 and 3 are 0.
- R8: In every cycle, `stat_out` bits 0, 4, 5, 6 and 7 equal `stat_in` from the previous cycle. In cycles without an abort, all eight bits do.
- R9: `op_cancel` goes high together with `abort_pulse` when, as chip select rises, `busy_in` is 1 or `stat_in` bit 2 or bit 3 is 1. Otherwise it stays 0.
- R10: While `rst_n` is low and in the first cycle after reset, `abort_pulse`, `op_cancel` and `stat_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cs_n_in | input | 1 | Serial chip select, active low (asynchronous) |
| sck_in | input | 1 | Serial clock, idles low (asynchronous) |
| mosi_in | input | 1 | Serial data in (asynchronous) |
| busy_in | input | 1 | A program or erase operation is running |
| stat_in | input | 8 | Current status byte |
| abort_pulse | output | 1 | One-cycle command to stop the program/erase engine |
| op_cancel | output | 1 | The abort ended a running or suspended operation |
| stat_out | output | 8 | Status byte after the abort update |

## Verification
The assertions assume that the serial clock runs much slower than the system clock, so every synchronised level lasts at least two system cycles. They also assume that `sck_in` is low whenever chip select changes, as mode 0 requires. The bench holds each serial-clock phase for four system clocks. It changes data only while the serial clock is low, and it raises and lowers chip select only with the serial clock idle. The bench holds `stat_in` and `busy_in` steady for the whole of a frame and a few cycles after it, so the value sampled as chip select rises is well defined.

// File: rtl/flash_abort_decoder.sv
module flash_abort_decoder #(
  parameter int          SW      = 8,
  parameter int          SYNC    = 2,
  parameter logic [7:0]  OPCODE  = 8'hF0,
  parameter logic [7:0]  CONFIRM = 8'hD0,
  parameter int          WEL_BIT = 1,
  parameter int          PS_BIT  = 2,
  parameter int          ES_BIT  = 3,
  parameter int          EN_BIT  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n_in,
  input  logic          sck_in,
  input  logic          mosi_in,
  input  logic          busy_in,
  input  logic [SW-1:0] stat_in,
  output logic          abort_pulse,
  output logic          op_cancel,
  output logic [SW-1:0] stat_out
);

  localparam logic [SW-1:0] CLR_MASK =
    (SW'(1) << WEL_BIT) | (SW'(1) << PS_BIT) | (SW'(1) << ES_BIT);

  logic [SYNC-1:0] cs_sy, sck_sy, mo_sy;
  logic            cs_d, sck_d;
  logic [2:0]      bit_ph;
  logic [1:0]      byte_n;
  logic [6:0]      sh;
  logic            opc_ok, seq_ok, armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_sy  <= '1;
      sck_sy <= '0;
      mo_sy  <= '0;
      cs_d   <= 1'b1;
      sck_d  <= 1'b0;
    end else begin
      cs_sy  <= {cs_sy[SYNC-2:0], cs_n_in};
      sck_sy <= {sck_sy[SYNC-2:0], sck_in};
      mo_sy  <= {mo_sy[SYNC-2:0], mosi_in};
      cs_d   <= cs_sy[SYNC-1];
      sck_d  <= sck_sy[SYNC-1];
    end
  end

  wire       cs_s      = cs_sy[SYNC-1];
  wire       sck_rise  = sck_sy[SYNC-1] & ~sck_d & ~cs_s;
  wire       cs_rise   = cs_s & ~cs_d;
  wire [7:0] byte_now  = {sh, mo_sy[SYNC-1]};
  wire       on_bound  = (bit_ph == 3'd0);
  wire       fire      = cs_rise & seq_ok & on_bound & stat_in[EN_BIT];
  wire       had_op    = busy_in | stat_in[PS_BIT] | stat_in[ES_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_ph <= '0;
      byte_n <= '0;
      sh     <= '0;
      opc_ok <= 1'b0;
      seq_ok <= 1'b0;
    end else if (cs_s) begin
      bit_ph <= '0;
      byte_n <= '0;
      sh     <= '0;
      opc_ok <= 1'b0;
      seq_ok <= 1'b0;
    end else if (sck_rise) begin
      sh     <= byte_now[6:0];
      bit_ph <= bit_ph + 3'd1;
      if (bit_ph == 3'd7) begin
        if (byte_n == 2'd0) opc_ok <= (byte_now == OPCODE);
        if (byte_n == 2'd1) seq_ok <= opc_ok && (byte_now == CONFIRM);
        if (byte_n != 2'd2) byte_n <= byte_n + 2'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      abort_pulse <= 1'b0;
      op_cancel   <= 1'b0;
      stat_out    <= '0;
      armed       <= 1'b0;
    end else begin
      abort_pulse <= fire;
      op_cancel   <= fire & had_op;
      stat_out    <= fire ? (stat_in & ~CLR_MASK) : stat_in;
      armed       <= 1'b1;
    end
  end

  p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pulse |=> !abort_pulse);

  p_needs_enable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pulse |-> $past(stat_in[EN_BIT]));

  p_flags_cleared_r7: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pulse |-> ((stat_out & CLR_MASK) == '0));

  p_keep_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> ((stat_out & ~CLR_MASK) == ($past(stat_in) & ~CLR_MASK)));

  p_idle_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !abort_pulse) |-> (stat_out == $past(stat_in)));

  p_cancel_with_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
    op_cancel |-> abort_pulse);

  p_boundary_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && !on_bound) |=> !abort_pulse);

endmodule

// File: tb/flash_abort_decoder_bench.sv
module flash_abort_decoder_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n_in = 1'b1, sck_in = 1'b0, mosi_in = 1'b0, busy_in = 1'b0;
  logic [7:0] stat_in = 8'h00;
  logic       abort_pulse, op_cancel;
  logic [7:0] stat_out;

  int total = 0, bad = 0, cycles = 0;
  bit finished = 0;
  string cur_tag = "R10";

  flash_abort_decoder u_flash_abort_decoder (
    .clk(clk), .rst_n(rst_n), .cs_n_in(cs_n_in), .sck_in(sck_in),
    .mosi_in(mosi_in), .busy_in(busy_in), .stat_in(stat_in),
    .abort_pulse(abort_pulse), .op_cancel(op_cancel), .stat_out(stat_out));

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference: pin delay queues and integer bit count
  bit   q_cs[$], q_sck[$], q_mo[$];
  bit   m_csd, m_sckd;
  int   m_bits;
  int   m_val;
  int   m_first, m_second;
  bit   e_abort, e_cancel;
  logic [7:0] e_stat;

  always @(posedge clk) begin
    if (!rst_n) begin
      q_cs = '{1, 1}; q_sck = '{0, 0}; q_mo = '{0, 0};
      m_csd = 1; m_sckd = 0; m_bits = 0; m_val = 0; m_first = -1; m_second = -1;
      e_abort = 0; e_cancel = 0; e_stat = 8'h00;
    end else begin
      bit cs_now, sck_now, mo_now, fire;
      cs_now = q_cs[0]; sck_now = q_sck[0]; mo_now = q_mo[0];
      fire = cs_now && !m_csd && (m_bits % 8 == 0) &&
             m_first == 8'hF0 && m_second == 8'hD0 && stat_in[4];
      e_abort  = fire;
      e_cancel = fire && (busy_in || stat_in[2] || stat_in[3]);
      e_stat   = fire ? (stat_in & 8'hF1) : stat_in;
      if (cs_now) begin
        m_bits = 0; m_val = 0; m_first = -1; m_second = -1;
      end else if (sck_now && !m_sckd) begin
        m_val = ((m_val << 1) | int'(mo_now)) & 8'hFF;
        m_bits++;
        if (m_bits == 8)  m_first  = m_val;
        if (m_bits == 16) m_second = m_val;
      end
      m_csd = cs_now; m_sckd = sck_now;
      void'(q_cs.pop_front());  q_cs.push_back(cs_n_in);
      void'(q_sck.pop_front()); q_sck.push_back(sck_in);
      void'(q_mo.pop_front());  q_mo.push_back(mosi_in);
    end
  end

  int n_pulse = 0, n_cancel = 0;
  logic [7:0] pulse_stat = 8'h00;

  always @(negedge clk) begin
    if (!finished) begin
      total++;
      if (abort_pulse !== e_abort || op_cancel !== e_cancel || stat_out !== e_stat) begin
        bad++;
        $display("FAIL %s cycle-model: got abort=%0b cancel=%0b stat=%02h exp abort=%0b cancel=%0b stat=%02h",
                 cur_tag, abort_pulse, op_cancel, stat_out, e_abort, e_cancel, e_stat);
      end
      if (abort_pulse === 1'b1) begin n_pulse++; pulse_stat = stat_out; end
      if (op_cancel === 1'b1) n_cancel++;
    end
  end

  task automatic check(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(input logic [63:0] data, input int nbits,
                       input logic [7:0] st, input logic bz);
    stat_in = st; busy_in = bz;
    n_pulse = 0; n_cancel = 0;
    wait_clk(2);
    cs_n_in = 1'b0;
    wait_clk(HALF);
    for (int i = 0; i < nbits; i++) begin
      mosi_in = data[nbits-1-i];
      wait_clk(HALF);
      sck_in = 1'b1;
      wait_clk(HALF);
      sck_in = 1'b0;
    end
    wait_clk(HALF);
    cs_n_in = 1'b1;
    wait_clk(10);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1;
      bad++; total++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    wait_clk(5);
    cur_tag = "R10";
    check("R10 reset abort", abort_pulse, 0);
    check("R10 reset cancel", op_cancel, 0);
    check("R10 reset stat", stat_out, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R10 first cycle stat", stat_out, 0);
    wait_clk(3);

    cur_tag = "R2";
    frame(64'hF0D0, 16, 8'h10, 1'b0);
    check("R2 one pulse", n_pulse, 1);
    check("R4 fires with write-enable latch clear", n_pulse, 1);

    cur_tag = "R7";
    frame(64'hF0D0, 16, 8'hBE, 1'b0);
    check("R7 pulse", n_pulse, 1);
    check("R7 R8 stat at pulse", pulse_stat, 8'hB0);
    check("R9 cancel on suspend", n_cancel, 1);
    check("R8 stat after", stat_out, 8'hBE);

    cur_tag = "R3";
    frame(64'hF0D0, 16, 8'h0E, 1'b1);
    check("R3 disabled no pulse", n_pulse, 0);
    check("R3 stat unchanged", stat_out, 8'h0E);

    cur_tag = "R5";
    frame(64'hF0D, 12, 8'h12, 1'b0);
    check("R5 partial confirm", n_pulse, 0);
    frame(64'hF0D0A, 20, 8'h12, 1'b0);
    check("R5 trailing half byte", n_pulse, 0);

    cur_tag = "R6";
    frame(64'hF0D1, 16, 8'h12, 1'b0);
    check("R6 wrong confirm", n_pulse, 0);
    frame(64'hF1D0, 16, 8'h12, 1'b0);
    check("R6 wrong opcode", n_pulse, 0);
    frame(64'hF0D0AA55, 32, 8'h12, 1'b0);
    check("R6 trailing bytes ignored", n_pulse, 1);
    check("R4 R7 stat trailing", pulse_stat, 8'h10);

    cur_tag = "R9";
    frame(64'hF0D0, 16, 8'h10, 1'b1);
    check("R9 cancel on busy", n_cancel, 1);
    frame(64'hF0D0, 16, 8'h10, 1'b0);
    check("R9 no cancel when idle", n_cancel, 0);
    check("R9 pulse when idle", n_pulse, 1);

    cur_tag = "R1";
    frame(64'hF0, 8, 8'h10, 1'b0);
    check("R1 opcode only frame", n_pulse, 0);
    frame(64'hD0, 8, 8'h10, 1'b0);
    check("R1 confirm in new frame", n_pulse, 0);
    frame(64'h7F0D0, 20, 8'h10, 1'b0);
    check("R1 misaligned frame", n_pulse, 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule